// File: doc/BRIEF.md
# Asynchronous Static Memory Phase Sequencer

This block runs one asynchronous read or write to an external static memory: an SRAM, a PSRAM or a NOR-flash-style part. The system side starts an access by raising a request with a direction, an address and, for a write, the write data. It keeps the request high until it sees a one-cycle acknowledge. For a read, the captured data is valid when the acknowledge appears.

Each access has up to three phases, always in the same order:
- an address setup phase;
- an address hold phase, which exists only when the address and data share one bus;
- a data phase.

The length of each phase, in system clock cycles, comes from a 16-bit timing register that software can write. After reset the register holds the slowest setting. When synchronous mode is selected, the programmed lengths are ignored and a fixed minimal timing is used.

On the memory side the block drives chip select, output enable, write enable, an address-valid strobe and a full address bus. It also drives a shared address/data bus with its own output enable and reads returning data from that bus. In multiplexed mode the low address bits travel on the shared bus before the data phase.

Top module: `smc_phase_seq`

## Requirements
- R1: After reset, the timing register reads 16'hFFFF (data 255, hold 15, setup 15). Chip select, output enable, write enable and the address-valid strobe are high, and the acknowledge is low.
- R2: The timing register keeps the data length in bits 15:8, the hold length in bits 7:4 and the setup length in bits 3:0. A write of `cfg_wdata` with `cfg_we` high reads back unchanged on `cfg_rdata` after the next clock edge.
- R3: The setup phase lasts S cycles, where S is bits 3:0. In this phase chip select and the address-valid strobe are low, and output enable and write enable are high. When S is 0 the phase is skipped.
- R4: The hold phase occurs only when `mux_en` is high. It lasts H cycles, where H is bits 7:4 and 0 counts as 1. In this phase chip select and the strobe are low, and the shared bus drives `req_addr[DW-1:0]`.
- R5: The data phase lasts D cycles, where D is bits 15:8 and 0 counts as 1. In this phase chip select stays low and the strobe is high. A read holds output enable low with the shared bus released. A write holds write enable low and drives `req_wdata` on the shared bus. Output enable and write enable are never low together.
- R6: The cycle after the data phase ends, `ack` is high for exactly one cycle with chip select high. For a read, `rd_data` then equals the value on `mem_ad_in` in the last data-phase cycle.
- R7: When `sync_en` is high at the start of an access, the register is ignored. The access uses no setup, a 1-cycle hold (multiplexed only) and a 1-cycle data phase.
- R8: The timing, mode and request fields are sampled when an access starts. A register write during an access changes only later accesses.
- R9: `mem_addr` carries the request address unchanged throughout an access. In setup, the shared bus carries the low address bits only in multiplexed mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_wdata | input | 16 | Timing register write value |
| cfg_rdata | output | 16 | Timing register contents |
| mux_en | input | 1 | Multiplexed address/data mode |
| sync_en | input | 1 | Synchronous mode; programmed lengths ignored |
| req | input | 1 | Access request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Captured read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_addr | output | AW | Address bus |
| mem_ad_out | output | DW | Shared bus drive value |
| mem_ad_oe | output | 1 | Shared bus drive enable |
| mem_ad_in | input | DW | Shared bus input |

## Verification
The hardest case to reach is a register write that lands in the middle of a running access. The write must leave the remaining phase lengths of that access untouched and take effect on the next one. The bench issues the write at a chosen cycle inside the data phase, keeps checking the old lengths to the end, and then runs a second access against the new value. The zero-valued fields, where reserved codes become one cycle and a zero setup drops the phase, are reached by writing all-zero and mixed values before multiplexed and non-multiplexed accesses.

// File: rtl/smc_pkg.sv
package smc_pkg;

    localparam int DLEN_W = 8;
    localparam int HLEN_W = 4;
    localparam int SLEN_W = 4;
    localparam int TREG_W = DLEN_W + HLEN_W + SLEN_W;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_HOLD  = 2'd2,
        PH_DATA  = 2'd3
    } phase_e;

    // field order matches the register bit layout: data high, setup low
    typedef struct packed {
        logic [DLEN_W-1:0] dlen;
        logic [HLEN_W-1:0] hlen;
        logic [SLEN_W-1:0] slen;
    } timing_t;

    localparam timing_t TIMING_SLOWEST = '{dlen: '1, hlen: '1, slen: '1};

    // lengths actually used for one access
    function automatic timing_t eff_timing(timing_t raw, logic sync);
        timing_t t;
        if (sync) begin
            t.slen = '0;
            t.hlen = HLEN_W'(1);
            t.dlen = DLEN_W'(1);
        end else begin
            t.slen = raw.slen;
            t.hlen = (raw.hlen == '0) ? HLEN_W'(1) : raw.hlen;
            t.dlen = (raw.dlen == '0) ? DLEN_W'(1) : raw.dlen;
        end
        return t;
    endfunction

    function automatic logic [DLEN_W-1:0] hold_m1(logic [HLEN_W-1:0] h);
        return {{(DLEN_W-HLEN_W){1'b0}}, h} - DLEN_W'(1);
    endfunction

    function automatic logic [DLEN_W-1:0] setup_m1(logic [SLEN_W-1:0] s);
        return {{(DLEN_W-SLEN_W){1'b0}}, s} - DLEN_W'(1);
    endfunction

endpackage

// File: rtl/smc_timing_reg.sv
module smc_timing_reg
    import smc_pkg::*;
#(
    parameter timing_t RST_VAL = TIMING_SLOWEST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [TREG_W-1:0] wdata,
    output timing_t           q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= RST_VAL;
        else if (we)
            q <= timing_t'(wdata);
    end
endmodule

// File: rtl/smc_phase_ctr.sv
module smc_phase_ctr
    import smc_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          mux_en,
    input  logic          sync_en,
    input  timing_t       tim,
    input  logic [DW-1:0] mem_ad_in,
    output phase_e        phase,
    output logic          mux_q,
    output logic          write_q,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic          ack,
    output logic [DW-1:0] rd_data
);
    timing_t           eff_c;
    logic [HLEN_W-1:0] lat_h;
    logic [DLEN_W-1:0] lat_d;
    logic [DLEN_W-1:0] cnt, cnt_d;
    phase_e            phase_d;
    logic              start, done;

    assign eff_c = eff_timing(tim, sync_en);

    always_comb begin
        phase_d = phase;
        cnt_d   = cnt;
        start   = 1'b0;
        done    = 1'b0;
        unique case (phase)
            PH_IDLE: begin
                if (req && !ack) begin
                    start = 1'b1;
                    if (eff_c.slen != '0) begin
                        phase_d = PH_SETUP;
                        cnt_d   = setup_m1(eff_c.slen);
                    end else if (mux_en) begin
                        phase_d = PH_HOLD;
                        cnt_d   = hold_m1(eff_c.hlen);
                    end else begin
                        phase_d = PH_DATA;
                        cnt_d   = eff_c.dlen - DLEN_W'(1);
                    end
                end
            end
            PH_SETUP: begin
                if (cnt == '0) begin
                    if (mux_q) begin
                        phase_d = PH_HOLD;
                        cnt_d   = hold_m1(lat_h);
                    end else begin
                        phase_d = PH_DATA;
                        cnt_d   = lat_d - DLEN_W'(1);
                    end
                end else begin
                    cnt_d = cnt - DLEN_W'(1);
                end
            end
            PH_HOLD: begin
                if (cnt == '0) begin
                    phase_d = PH_DATA;
                    cnt_d   = lat_d - DLEN_W'(1);
                end else begin
                    cnt_d = cnt - DLEN_W'(1);
                end
            end
            PH_DATA: begin
                if (cnt == '0) begin
                    phase_d = PH_IDLE;
                    done    = 1'b1;
                end else begin
                    cnt_d = cnt - DLEN_W'(1);
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            ack     <= 1'b0;
            rd_data <= '0;
            lat_h   <= '0;
            lat_d   <= '0;
            mux_q   <= 1'b0;
            write_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            phase <= phase_d;
            cnt   <= cnt_d;
            ack   <= done;
            if (done && !write_q)
                rd_data <= mem_ad_in;
            if (start) begin
                lat_h   <= eff_c.hlen;
                lat_d   <= eff_c.dlen;
                mux_q   <= mux_en;
                write_q <= req_we;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
        end
    end
endmodule

// File: rtl/smc_pin_drv.sv
module smc_pin_drv
    import smc_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  phase_e        phase,
    input  logic          mux_q,
    input  logic          write_q,
    input  logic [AW-1:0] addr_q,
    input  logic [DW-1:0] wdata_q,
    output logic          mem_cs_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic          mem_adv_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_ad_out,
    output logic          mem_ad_oe
);
    logic in_addr, in_data;

    assign in_addr = (phase == PH_SETUP) || (phase == PH_HOLD);
    assign in_data = (phase == PH_DATA);

    always_comb begin
        mem_cs_n   = !(in_addr || in_data);
        mem_adv_n  = !in_addr;
        mem_oe_n   = !(in_data && !write_q);
        mem_we_n   = !(in_data && write_q);
        mem_addr   = addr_q;
        mem_ad_oe  = 1'b0;
        mem_ad_out = '0;
        if (in_addr && mux_q) begin
            mem_ad_oe  = 1'b1;
            mem_ad_out = addr_q[DW-1:0];
        end else if (in_data && write_q) begin
            mem_ad_oe  = 1'b1;
            mem_ad_out = wdata_q;
        end
    end
endmodule

// File: rtl/smc_phase_seq.sv
module smc_phase_seq
    import smc_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [15:0]   cfg_wdata,
    output logic [15:0]   cfg_rdata,
    input  logic          mux_en,
    input  logic          sync_en,
    input  logic          req,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          ack,
    output logic [DW-1:0] rd_data,
    output logic          mem_cs_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic          mem_adv_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_ad_out,
    output logic          mem_ad_oe,
    input  logic [DW-1:0] mem_ad_in
);
    timing_t       tim;
    phase_e        phase;
    logic          mux_q, write_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;

    smc_timing_reg #(.RST_VAL(TIMING_SLOWEST)) u_treg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .q     (tim)
    );

    assign cfg_rdata = tim;

    smc_phase_ctr #(.AW(AW), .DW(DW)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mux_en    (mux_en),
        .sync_en   (sync_en),
        .tim       (tim),
        .mem_ad_in (mem_ad_in),
        .phase     (phase),
        .mux_q     (mux_q),
        .write_q   (write_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .ack       (ack),
        .rd_data   (rd_data)
    );

    smc_pin_drv #(.AW(AW), .DW(DW)) u_pins (
        .phase      (phase),
        .mux_q      (mux_q),
        .write_q    (write_q),
        .addr_q     (addr_q),
        .wdata_q    (wdata_q),
        .mem_cs_n   (mem_cs_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_adv_n  (mem_adv_n),
        .mem_addr   (mem_addr),
        .mem_ad_out (mem_ad_out),
        .mem_ad_oe  (mem_ad_oe)
    );
endmodule

// File: rtl/smc_phase_seq_sva.sv
module smc_phase_seq_sva #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst,
    input logic [15:0]   cfg_rdata,
    input logic          ack,
    input logic          mem_cs_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          mem_adv_n,
    input logic [AW-1:0] mem_addr
);
    AST_RESET_SLOWEST: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cfg_rdata == 16'hFFFF); // R1
    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (rst)
        !mem_adv_n |-> !mem_cs_n); // R3
    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n)); // R5
    AST_NO_STROBE_IN_DATA: assert property (@(posedge clk) disable iff (rst)
        (!mem_oe_n || !mem_we_n) |-> (mem_adv_n && !mem_cs_n)); // R5
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack); // R6
    AST_ACK_IDLE: assert property (@(posedge clk) disable iff (rst)
        ack |-> mem_cs_n); // R6
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R9
endmodule

bind smc_phase_seq smc_phase_seq_sva #(.AW(AW)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .cfg_rdata (cfg_rdata),
    .ack       (ack),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_adv_n (mem_adv_n),
    .mem_addr  (mem_addr)
);

// File: tb/smc_phase_seq_tb.sv
module smc_phase_seq_tb;
    localparam int AW = 24;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [15:0]   cfg_wdata = '0;
    logic [15:0]   cfg_rdata;
    logic          mux_en = 1'b0, sync_en = 1'b0;
    logic          req = 1'b0, req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          ack;
    logic [DW-1:0] rd_data;
    logic          mem_cs_n, mem_oe_n, mem_we_n, mem_adv_n, mem_ad_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_ad_out;
    logic [DW-1:0] mem_ad_in = '0;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] cfg_model;

    always #2 clk = ~clk;

    smc_phase_seq #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .mux_en(mux_en), .sync_en(sync_en),
        .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .ack(ack), .rd_data(rd_data), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_adv_n(mem_adv_n), .mem_addr(mem_addr),
        .mem_ad_out(mem_ad_out), .mem_ad_oe(mem_ad_oe), .mem_ad_in(mem_ad_in)
    );

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // pin vector {cs_n, adv_n, oe_n, we_n, ad_oe, ack}
    function automatic logic [5:0] pins();
        return {mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n, mem_ad_oe, ack};
    endfunction

    task automatic write_cfg(logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_model = v;
        check("R2 readback", cfg_rdata, v);
    endtask

    // one access against the reference timeline; optional cfg write at cycle wr_at
    task automatic run_access(logic we, logic mux, logic syn, logic [AW-1:0] addr,
                              logic [DW-1:0] wd, logic [DW-1:0] pat,
                              int wr_at, logic [15:0] wr_val);
        int s, h, d, n;
        s = syn ? 0 : int'(cfg_model[3:0]);
        h = !mux ? 0 : (syn ? 1 : ((cfg_model[7:4] == 0) ? 1 : int'(cfg_model[7:4])));
        d = syn ? 1 : ((cfg_model[15:8] == 0) ? 1 : int'(cfg_model[15:8]));
        n = s + h + d;
        @(negedge clk);
        mux_en = mux; sync_en = syn; req_we = we; req_addr = addr;
        req_wdata = wd; mem_ad_in = pat; req = 1'b1;
        for (int i = 0; i < n; i++) begin
            logic addr_ph, data_ph;
            logic [5:0] ep;
            string tag;
            @(negedge clk);
            addr_ph = (i < s + h);
            data_ph = !addr_ph;
            tag = (i < s) ? "R3 setup" : (addr_ph ? "R4 hold" : "R5 data");
            ep = {1'b0, !addr_ph, !(data_ph && !we), !(data_ph && we),
                  (addr_ph && mux) || (data_ph && we), 1'b0};
            check(tag, pins(), ep);
            check("R9 addr", mem_addr, addr);
            if (addr_ph && mux)  check("R4 muxed address", mem_ad_out, addr[DW-1:0]);
            if (data_ph && we)   check("R5 write data", mem_ad_out, wd);
            cfg_we = (i == wr_at);
            cfg_wdata = wr_val;
            if (i == wr_at) cfg_model = wr_val;
            // a different value in the last data cycle would expose early capture
            mem_ad_in = (i == n - 1) ? pat : ~pat;
        end
        @(negedge clk);
        cfg_we = 1'b0;
        check("R6 ack cycle", pins(), 6'b111101);
        if (!we) check("R6 read data", rd_data, pat);
        req = 1'b0;
        @(negedge clk);
        check("R6 ack single", pins(), 6'b111100);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        cfg_model = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset timing", cfg_rdata, 16'hFFFF);
        check("R1 reset pins", pins(), 6'b111100);
        // R1: slowest defaults drive a 15/15/255 multiplexed read
        run_access(1'b0, 1'b1, 1'b0, 24'hABC123, 16'h0, 16'h5A5A, -1, 16'h0);
        // R2 field layout
        write_cfg(16'hA573);
        write_cfg(16'h0302);
        run_access(1'b1, 1'b0, 1'b0, 24'h000044, 16'hBEEF, 16'h0, -1, 16'h0);
        run_access(1'b0, 1'b1, 1'b0, 24'h12F0F0, 16'h0, 16'h1357, -1, 16'h0);
        // R3 skip, R4/R5 reserved zero counted as one
        write_cfg(16'h0000);
        run_access(1'b0, 1'b1, 1'b0, 24'h00ABCD, 16'h0, 16'h2468, -1, 16'h0);
        run_access(1'b1, 1'b1, 1'b0, 24'h001111, 16'hC0DE, 16'h0, -1, 16'h0);
        run_access(1'b0, 1'b0, 1'b0, 24'h777777, 16'h0, 16'h8001, -1, 16'h0);
        // R7 synchronous mode ignores fields
        write_cfg(16'h20F5);
        run_access(1'b0, 1'b1, 1'b1, 24'h0F0F0F, 16'h0, 16'h4321, -1, 16'h0);
        run_access(1'b1, 1'b0, 1'b1, 24'h0A0A0A, 16'h9999, 16'h0, -1, 16'h0);
        // R8 mid-access write affects only the next access
        write_cfg(16'h0421);
        run_access(1'b1, 1'b1, 1'b0, 24'h345678, 16'h7E7E, 16'h0, 4, 16'h0112);
        check("R8 register updated", cfg_rdata, 16'h0112);
        run_access(1'b0, 1'b1, 1'b0, 24'h345679, 16'h0, 16'h6655, -1, 16'h0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule